// File: doc/BRIEF.md
# Multi-Register Load Sequencer

This block carries out a load of several registers from consecutive word addresses. A single start pulse supplies a base byte address, a bitmap of the registers to fill, the index of the base register and a writeback flag. The sequencer then issues one memory read per selected register, walking the bitmap from the lowest register up. For each returned word it emits a register write carrying the destination index. A word bound for the top register, the program counter, goes out on a separate branch output instead.

Once all words have arrived, the block can present an updated base value for the register file to write back. It then ends the sequence with a done pulse. The block keeps a copy of every start operand, so the base used for writeback is the value seen at start, even when the list overwrites the base register partway through.

The two malformed cases are flagged rather than passed silently. An empty bitmap raises an error. A writeback whose base register is also in the list raises an undefined-value flag.

Top module: `lm_seq`

## Requirements
- R1: A start pulse is accepted only when `busy_o` is low. `busy_o` is high from the cycle after an accepted start through the cycle of `done_o`, and a start seen while busy changes nothing in the running sequence.
- R2: Reads go out in ascending register order. The first read address is the base sampled at start, and each later read address is 4 greater than the one before.
- R3: Only one read is outstanding. `rd_req_o` stays high with a stable `rd_addr_o` until `rd_valid_i` is sampled high on a clock edge.
- R4: A read completed for register index 0 to 14 gives a one-cycle `wr_en_o` pulse in the next cycle, with that index on `wr_idx_o` and the returned word on `wr_data_o`.
- R5: A read completed for register index 15 gives a one-cycle `br_en_o` pulse with the word on `br_addr_o`, and no `wr_en_o` pulse. It is always the last word of the sequence.
- R6: With writeback set and the base register not in the bitmap, `wb_en_o` pulses for one cycle in the cycle after the last write or branch pulse. In that cycle `wb_idx_o` is the base index, `wb_data_o` is the start base plus 4 times the number of set bits, and `wb_unknown_o` is low.
- R7: With writeback set and the base register in the bitmap, the `wb_en_o` pulse comes with `wb_unknown_o` high, and `wb_data_o` carries no defined value.
- R8: An all-zero bitmap issues no read, no write and no writeback. `done_o` and `err_empty_o` are both high in the cycle after the start.
- R9: `done_o` is a one-cycle pulse. It comes in the cycle after the last write or branch pulse without writeback, or in the cycle after the `wb_en_o` pulse with writeback. `err_empty_o` is low on every other done.
- R10: The base address, bitmap, index and writeback flag are sampled at start. Changing these inputs during a sequence has no effect.
- R11: After reset, `busy_o`, `rd_req_o`, `wr_en_o`, `br_en_o`, `wb_en_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | 32 | Base byte address |
| reg_mask_i | input | 16 | Register bitmap, bit i selects register i |
| base_idx_i | input | 4 | Index of the base register |
| wback_i | input | 1 | Write back the updated base |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 32 | Read data |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 4 | Register write index |
| wr_data_o | output | 32 | Register write data |
| br_en_o | output | 1 | Branch strobe for a loaded program counter |
| br_addr_o | output | 32 | Branch target |
| wb_en_o | output | 1 | Base writeback strobe |
| wb_idx_o | output | 4 | Base register index |
| wb_data_o | output | 32 | Updated base value |
| wb_unknown_o | output | 1 | Writeback value undefined (base in list) |
| err_empty_o | output | 1 | Empty bitmap, valid with done_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one cycle |

## Verification
The hardest case to reach from the ports is a start that arrives while a sequence is running and overlaps a read that is still waiting for its response. The stimulus stalls `rd_valid_i` for up to two cycles. It fires a second start with a different bitmap during a multi-word sequence, and it corrupts the start operands right after acceptance. The words then delivered must still follow the first bitmap from the first base. The sweep mixes bitmaps that include and exclude the base register, bitmaps that end on the branch entry, and the empty bitmap.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_TAIL,
    ST_WB,
    ST_DONE
  } lm_state_e;
endpackage

// File: rtl/lm_lowbit.sv
module lm_lowbit #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o
);
  // downward scan leaves the lowest set bit
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lm_popcnt.sv
module lm_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(mask_i[i]);
  end
endmodule

// File: rtl/lm_seq.sv
module lm_seq
  import lm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW        = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_addr_i,
  input  logic [NREG-1:0] reg_mask_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic            wback_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            wr_en_o,
  output logic [IW-1:0]   wr_idx_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            br_en_o,
  output logic [DW-1:0]   br_addr_o,
  output logic            wb_en_o,
  output logic [IW-1:0]   wb_idx_o,
  output logic [AW-1:0]   wb_data_o,
  output logic            wb_unknown_o,
  output logic            err_empty_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);
  localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);

  lm_state_e       state_q;
  logic [AW-1:0]   addr_q, base_q;
  logic [NREG-1:0] rem_q, rem_nxt;
  logic [IW-1:0]   bidx_q, cur_idx, out_idx_q;
  logic [CW-1:0]   cnt_q, start_cnt;
  logic [DW-1:0]   out_data_q;
  logic            wb_q, in_list_q, empty_q, out_en_q, out_pc_q;

  lm_lowbit #(.N(NREG), .IW(IW)) u_lowbit (
    .mask_i (rem_q),
    .idx_o  (cur_idx)
  );

  lm_popcnt #(.N(NREG), .CW(CW)) u_popcnt (
    .mask_i (reg_mask_i),
    .cnt_o  (start_cnt)
  );

  // drop the lowest set bit
  assign rem_nxt = rem_q & (rem_q - NREG'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      base_q     <= '0;
      rem_q      <= '0;
      bidx_q     <= '0;
      cnt_q      <= '0;
      wb_q       <= 1'b0;
      in_list_q  <= 1'b0;
      empty_q    <= 1'b0;
      out_en_q   <= 1'b0;
      out_pc_q   <= 1'b0;
      out_idx_q  <= '0;
      out_data_q <= '0;
    end else begin
      out_en_q <= 1'b0;
      out_pc_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q    <= base_addr_i;
            addr_q    <= base_addr_i;
            rem_q     <= reg_mask_i;
            bidx_q    <= base_idx_i;
            wb_q      <= wback_i;
            in_list_q <= reg_mask_i[base_idx_i];
            cnt_q     <= start_cnt;
            empty_q   <= (reg_mask_i == '0);
            state_q   <= (reg_mask_i == '0) ? ST_DONE : ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_valid_i) begin
            out_idx_q  <= cur_idx;
            out_data_q <= rd_data_i;
            if (cur_idx == PC_IDX) out_pc_q <= 1'b1;
            else                   out_en_q <= 1'b1;
            addr_q  <= addr_q + STEP;
            rem_q   <= rem_nxt;
            state_q <= (rem_nxt != '0) ? ST_REQ : ST_TAIL;
          end
        end
        ST_TAIL: state_q <= wb_q ? ST_WB : ST_DONE;
        ST_WB:   state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o     = (state_q == ST_REQ);
  assign rd_addr_o    = addr_q;
  assign wr_en_o      = out_en_q;
  assign wr_idx_o     = out_idx_q;
  assign wr_data_o    = out_data_q;
  assign br_en_o      = out_pc_q;
  assign br_addr_o    = out_data_q;
  assign wb_en_o      = (state_q == ST_WB);
  assign wb_idx_o     = bidx_q;
  // value is meaningless when wb_unknown_o is set
  assign wb_data_o    = base_q + AW'(cnt_q) * STEP;
  assign wb_unknown_o = (state_q == ST_WB) && in_list_q;
  assign done_o       = (state_q == ST_DONE);
  assign err_empty_o  = (state_q == ST_DONE) && empty_q;
  assign busy_o       = (state_q != ST_IDLE);
endmodule

// File: rtl/lm_seq_chk.sv
module lm_seq_chk #(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW        = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [NREG-1:0] reg_mask_i,
  input logic            busy_o,
  input logic            rd_req_o,
  input logic            rd_valid_i,
  input logic [AW-1:0]   rd_addr_o,
  input logic            wr_en_o,
  input logic [IW-1:0]   wr_idx_o,
  input logic            br_en_o,
  input logic            wb_en_o,
  input logic            done_o,
  input logic            err_empty_o
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  // R1
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_valid_i) |=>
      (!rd_req_o || rd_addr_o == $past(rd_addr_o) + AW'(WORD_BYTES)));

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R4
  write_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_valid_i) |=> (wr_en_o || br_en_o));

  // R4
  write_not_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o != PC_IDX));

  // R5
  branch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_en_o |-> (!wr_en_o && !rd_req_o));

  // R8
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && reg_mask_i == '0) |=> (done_o && err_empty_o && !rd_req_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  wb_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> done_o);
endmodule

bind lm_seq lm_seq_chk #(
  .AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .reg_mask_i  (reg_mask_i),
  .busy_o      (busy_o),
  .rd_req_o    (rd_req_o),
  .rd_valid_i  (rd_valid_i),
  .rd_addr_o   (rd_addr_o),
  .wr_en_o     (wr_en_o),
  .wr_idx_o    (wr_idx_o),
  .br_en_o     (br_en_o),
  .wb_en_o     (wb_en_o),
  .done_o      (done_o),
  .err_empty_o (err_empty_o)
);

// File: tb/lm_seq_tb.sv
module lm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [15:0] reg_mask_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic        wback_i = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_req_o, wr_en_o, br_en_o, wb_en_o, wb_unknown_o;
  logic        err_empty_o, busy_o, done_o;
  logic [31:0] rd_addr_o, wr_data_o, br_addr_o, wb_data_o;
  logic [3:0]  wr_idx_o, wb_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lm_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .reg_mask_i(reg_mask_i), .base_idx_i(base_idx_i), .wback_i(wback_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .br_en_o(br_en_o), .br_addr_o(br_addr_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
    .wb_unknown_o(wb_unknown_o), .err_empty_o(err_empty_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic int lowest(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 190000", cycles);
      summary();
    end
  end

  task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                        input logic [3:0] bidx, input logic wb, input int lat,
                        input logic poke);
    logic [15:0] rem = mask;
    int k = 0, wcnt = 0, last_out = -10, wb_cyc = -10;
    logic wb_exp = wb && (mask != 0);
    logic wb_seen = 1'b0, finished = 1'b0;
    @(negedge clk);
    base_addr_i = base; reg_mask_i = mask; base_idx_i = bidx; wback_i = wb;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10: corrupt operands after the start was taken
    base_addr_i = ~base; reg_mask_i = ~mask; base_idx_i = ~bidx; wback_i = ~wb;
    chk("R1 busy after start", 32'(busy_o), 1);
    for (int cyc = 0; cyc < 300 && !finished; cyc++) begin
      rd_valid_i = 1'b0;
      if (poke && cyc == 1) start_i = 1'b1;
      if (poke && cyc == 2) start_i = 1'b0;
      if (wr_en_o) begin
        chk("R4 write index", 32'(wr_idx_o), 32'(lowest(rem)));
        chk("R4 write data", wr_data_o, memf(base + 32'(4 * k)));
        rem[lowest(rem)] = 1'b0;
        k++; last_out = cyc;
      end
      if (br_en_o) begin
        chk("R5 branch is last entry", 32'(lowest(rem)), 15);
        chk("R5 branch target", br_addr_o, memf(base + 32'(4 * k)));
        rem[15] = 1'b0;
        k++; last_out = cyc;
      end
      if (wb_en_o) begin
        wb_seen = 1'b1; wb_cyc = cyc;
        chk("R6 writeback expected", 32'(wb_exp), 1);
        chk("R6 writeback index", 32'(wb_idx_o), 32'(bidx));
        chk("R6 writeback after last word", 32'(cyc - last_out), 1);
        chk("R7 unknown flag", 32'(wb_unknown_o), 32'(mask[bidx]));
        if (!mask[bidx])
          chk("R6 writeback value", wb_data_o, base + 32'(4 * $countones(mask)));
      end
      if (rd_req_o)
        chk("R2 read address", rd_addr_o, base + 32'(4 * k));
      if (done_o) begin
        chk("R9 all words delivered", 32'(rem), 0);
        chk("R8 empty flag", 32'(err_empty_o), 32'(mask == 0));
        chk("R6 writeback seen", 32'(wb_seen), 32'(wb_exp));
        if (mask == 0) chk("R8 done timing", 32'(cyc), 0);
        else if (wb_exp) chk("R9 done after writeback", 32'(cyc - wb_cyc), 1);
        else chk("R9 done after last word", 32'(cyc - last_out), 1);
        finished = 1'b1;
      end else if (rd_req_o) begin
        if (wcnt >= lat) begin
          rd_valid_i = 1'b1;
          rd_data_i = memf(rd_addr_o);
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
      @(negedge clk);
    end
    rd_valid_i = 1'b0;
    start_i = 1'b0;
    if (!finished) chk("R9 done reached", 0, 1);
    chk("R1 idle after done", 32'(busy_o), 0);
    chk("R9 done single cycle", 32'(done_o), 0);
  endtask

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 busy reset", 32'(busy_o), 0);
    chk("R11 req reset", 32'(rd_req_o), 0);
    chk("R11 outputs reset", 32'({wr_en_o, br_en_o, wb_en_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 empty list, with and without writeback
    run_op(32'h100, 16'h0000, 4'd3, 1'b1, 0, 1'b0);
    run_op(32'h200, 16'h0000, 4'd0, 1'b0, 0, 1'b0);
    // single-register lists including the branch entry (R5)
    for (int b = 0; b < 16; b++)
      run_op(32'h1000 + 32'(b * 64), 16'(1 << b), 4'(b ^ 5), b[0], b % 3, 1'b0);
    // full list, base in list (R7) and branch last
    run_op(32'h8000, 16'hFFFF, 4'd4, 1'b1, 1, 1'b1);
    run_op(32'hFFFF_FFF0, 16'h8001, 4'd2, 1'b1, 2, 1'b1);
    // pseudo-random sweep across latencies, writeback and base membership
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_op({lcg[31:2], 2'b00}, lcg[23:8] ^ 16'(i), lcg[5:2], lcg[0] | lcg[7],
             i % 3, (i % 4) == 1 && $countones(lcg[23:8] ^ 16'(i)) > 1);
    end
    summary();
  end
endmodule